// File: doc/BRIEF.md
# SD/MMC Host Register and Interrupt Front End

This block is the software-visible front of a simplified SD/MMC host controller. A processor reaches it over a 32-bit register bus addressed in bytes, with one register per aligned word. Through it the processor sets a buffer address, a command argument, a block length and a block count, and reads back the card response, the card state and a masked set of interrupt events. The length and count registers hold the value minus one.

A single write to the command register issues a command. The block stores the word, splits it into opcode, response type, command class, open-drain, wait-for-busy and read-direction fields, and raises a one-cycle start pulse toward a card-side engine. That engine reports back through four event strobes: command done, data done, command timeout and card-detect change. On command done it also presents a 128-bit response, which the block latches according to the response type of the outstanding command. One interrupt line is raised while any enabled status bit is set. Software clears status bits by writing ones to them.

Top module: `sdhost_front`

## Requirements
- R1: After reset every register reads zero (status, enable, buffer address, command, argument, the four response words, block length, block count and the busy flag), `irq` is low and `cmdStart` is low.
- R2: The enable (word 0x04, bits [3:0]), buffer address (0x08), argument (0x10), block length (0x24) and block count (0x28) registers read back what was last written. Length and count keep only bits [10:0] and read zero above them. They drive `bufAddr`, `cmdArg`, `blkLenM1` and `blkCntM1`.
- R3: A write to the command register (0x0C) while idle stores the bits under mask 0xBB7F and raises `cmdStart` for exactly one cycle, in the cycle after the write. The command fields are taken from these bit positions: opcode [5:0], open-drain 6, response type [9:8], wait-for-busy 11, command class [13:12], read direction 15.
- R4: Bit 31 of the card state register (0x2C) is a busy flag. It is set by an accepted command write and cleared by command done or command timeout. A command write while busy is ignored: there is no start pulse and the command register keeps its old value.
- R5: Interrupt status (0x00) bit 0 is set by command done, bit 1 by data done, bit 2 by a card-detect change and bit 3 by command timeout.
- R6: Writing the status register clears each bit written as 1 and leaves the others. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R7: `irq` is high exactly when the bitwise AND of status and enable is nonzero.
- R8: When command timeout and command done arrive in the same cycle, only status bit 3 is set. Bit 0 stays clear and the response words are not loaded.
- R9: On command done, the response words load according to the stored response type. Type 2 (long) loads all four words, with word 0 (0x14) = response bits [31:0] and word 3 (0x20) = bits [127:96]. Types 1 and 3 load word 0 from bits [31:0] and clear words 1 to 3. Type 0 leaves all four words unchanged.
- R10: Card state bit 0 follows `cardInserted` and bit 1 follows `cardReadOnly`. Any change of the inserted input compared with the previous cycle (the value before reset counts as not inserted) sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 6 | Byte address; bits [1:0] ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| irq | output | 1 | Interrupt request |
| cmdStart | output | 1 | One-cycle command start pulse |
| cmdOpcode | output | 6 | Command opcode |
| cmdRespType | output | 2 | Response type: 0 none, 1 short, 2 long, 3 short without CRC class |
| cmdClass | output | 2 | 0 broadcast, 1 broadcast with response, 2 addressed, 3 addressed with data |
| cmdOpenDrain | output | 1 | Open-drain bus mode |
| cmdBusyWait | output | 1 | Wait for busy after the response |
| cmdReadDir | output | 1 | Data moves from card to host |
| cmdArg | output | 32 | Command argument |
| bufAddr | output | 32 | Buffer address |
| blkLenM1 | output | 11 | Block length minus one |
| blkCntM1 | output | 11 | Block count minus one |
| evCmdDone | input | 1 | Command finished strobe |
| evDataDone | input | 1 | Data phase finished strobe |
| evTimeout | input | 1 | Command timeout strobe |
| respIn | input | 128 | Response presented with `evCmdDone` |
| cardInserted | input | 1 | Card present level |
| cardReadOnly | input | 1 | Card write-protect level |

## Verification
A seeded random phase mixes register writes with random data, read-backs, data-done pulses, card insert and remove toggles, write-protect changes and status writes with random masks. After each step the bench compares status and `irq` against a model, which separates set from clear behaviour and shows whether masking follows the enable bits. Directed cases then issue commands of each response type and compare the long word order, the short-response zeroing and the unchanged words for type 0. Further directed cases cover the same-cycle timeout and done pair, a command written while busy, and an event arriving together with its own clear.

// File: rtl/sdhost_pkg.sv
package sdhost_pkg;
  // word indices (byte address >> 2)
  localparam logic [3:0] IDX_STAT  = 4'h0;
  localparam logic [3:0] IDX_EN    = 4'h1;
  localparam logic [3:0] IDX_BUF   = 4'h2;
  localparam logic [3:0] IDX_CMD   = 4'h3;
  localparam logic [3:0] IDX_ARG   = 4'h4;
  localparam logic [3:0] IDX_RESP0 = 4'h5;
  localparam logic [3:0] IDX_LEN   = 4'h9;
  localparam logic [3:0] IDX_CNT   = 4'hA;
  localparam logic [3:0] IDX_STATE = 4'hB;

  localparam int NEVT = 4;
  localparam logic [31:0] CMD_MASK = 32'h0000_BB7F;
  localparam logic [1:0] RESP_NONE = 2'd0;
  localparam logic [1:0] RESP_LONG = 2'd2;

  typedef struct packed {
    logic wrEn;
    logic wrBuf;
    logic wrArg;
    logic wrLen;
    logic wrCnt;
    logic wrCmd;
    logic loadResp;
    logic [NEVT-1:0] statClr;
    logic [NEVT-1:0] statSet;
  } ctrlStrb_t;
endpackage

// File: rtl/sdhost_ctrl.sv
module sdhost_ctrl
  import sdhost_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [5:0]  busAddr,
  input  logic [31:0] busWdata,
  input  logic        evCmdDone,
  input  logic        evDataDone,
  input  logic        evTimeout,
  input  logic        cardInserted,
  input  logic [1:0]  curRespType,
  output ctrlStrb_t   strb,
  output logic        busy,
  output logic        cmdStart
);
  logic [3:0] wordIdx;
  logic       prevIns;
  logic       cmdAccept;

  assign wordIdx   = busAddr[5:2];
  assign cmdAccept = busWr && (wordIdx == IDX_CMD) && !busy;

  always_comb begin
    strb          = '0;
    strb.wrEn     = busWr && (wordIdx == IDX_EN);
    strb.wrBuf    = busWr && (wordIdx == IDX_BUF);
    strb.wrArg    = busWr && (wordIdx == IDX_ARG);
    strb.wrLen    = busWr && (wordIdx == IDX_LEN);
    strb.wrCnt    = busWr && (wordIdx == IDX_CNT);
    strb.wrCmd    = cmdAccept;
    strb.statClr  = (busWr && (wordIdx == IDX_STAT)) ? busWdata[NEVT-1:0] : '0;
    // a timeout replaces the completion of the same command
    strb.statSet[0] = evCmdDone && !evTimeout;
    strb.statSet[1] = evDataDone;
    strb.statSet[2] = cardInserted != prevIns;
    strb.statSet[3] = evTimeout;
    strb.loadResp   = evCmdDone && !evTimeout && (curRespType != RESP_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      cmdStart <= 1'b0;
      prevIns  <= 1'b0;
    end else begin
      cmdStart <= cmdAccept;
      prevIns  <= cardInserted;
      if (cmdAccept) busy <= 1'b1;
      else if (evCmdDone || evTimeout) busy <= 1'b0;
    end
  end

  AST_START_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> busy); // R4
  AST_NO_START_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (wordIdx == IDX_CMD) && busy) |=> !cmdStart); // R4
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart); // R3
endmodule

// File: rtl/sdhost_dpath.sv
module sdhost_dpath
  import sdhost_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int RESP_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [5:0]        busAddr,
  input  logic [31:0]       busWdata,
  input  logic [RESP_W-1:0] respIn,
  input  logic              busy,
  input  logic              cardInserted,
  input  logic              cardReadOnly,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic [31:0]       cmdWord,
  output logic [31:0]       cmdArg,
  output logic [31:0]       bufAddr,
  output logic [LEN_W-1:0]  blkLenM1,
  output logic [LEN_W-1:0]  blkCntM1
);
  localparam int NWORDS = RESP_W / 32;

  logic [NEVT-1:0] stat;
  logic [NEVT-1:0] intEn;
  logic [31:0]     respWord [NWORDS];
  logic [3:0]      wordIdx;

  assign wordIdx = busAddr[5:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stat     <= '0;
      intEn    <= '0;
      cmdWord  <= '0;
      cmdArg   <= '0;
      bufAddr  <= '0;
      blkLenM1 <= '0;
      blkCntM1 <= '0;
    end else begin
      stat <= (stat & ~strb.statClr) | strb.statSet;
      if (strb.wrEn)  intEn    <= busWdata[NEVT-1:0];
      if (strb.wrBuf) bufAddr  <= busWdata;
      if (strb.wrArg) cmdArg   <= busWdata;
      if (strb.wrLen) blkLenM1 <= busWdata[LEN_W-1:0];
      if (strb.wrCnt) blkCntM1 <= busWdata[LEN_W-1:0];
      if (strb.wrCmd) cmdWord  <= busWdata & CMD_MASK;
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_resp
    always_ff @(posedge clk) begin
      if (!rstN) respWord[g] <= '0;
      else if (strb.loadResp)
        respWord[g] <= (g == 0 || cmdWord[9:8] == RESP_LONG) ? respIn[g*32 +: 32] : '0;
    end
  end

  assign irq = |(stat & intEn);

  always_comb begin
    busRdata = '0;
    if (wordIdx >= IDX_RESP0 && wordIdx < IDX_RESP0 + 4'(NWORDS))
      busRdata = respWord[wordIdx - IDX_RESP0];
    else
      case (wordIdx)
        IDX_STAT:  busRdata = 32'(stat);
        IDX_EN:    busRdata = 32'(intEn);
        IDX_BUF:   busRdata = bufAddr;
        IDX_CMD:   busRdata = cmdWord;
        IDX_ARG:   busRdata = cmdArg;
        IDX_LEN:   busRdata = 32'(blkLenM1);
        IDX_CNT:   busRdata = 32'(blkCntM1);
        IDX_STATE: busRdata = {busy, 29'd0, cardReadOnly, cardInserted};
        default:   busRdata = '0;
      endcase
  end

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.statSet) |=> ((stat & $past(strb.statSet)) == $past(strb.statSet))); // R6
  AST_TIMEOUT_NO_EOC: assert property (@(posedge clk) disable iff (!rstN)
    strb.statSet[3] |-> !strb.statSet[0]); // R8
  AST_RESP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadResp |=> $stable(respWord[0])); // R9
  AST_CLEAR_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statClr[1] && !strb.statSet[1]) |=> !stat[1]); // R6
endmodule

// File: rtl/sdhost_front.sv
module sdhost_front
  import sdhost_pkg::*;
#(
  parameter int LEN_W  = 11,
  parameter int RESP_W = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [5:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq,
  output logic              cmdStart,
  output logic [5:0]        cmdOpcode,
  output logic [1:0]        cmdRespType,
  output logic [1:0]        cmdClass,
  output logic              cmdOpenDrain,
  output logic              cmdBusyWait,
  output logic              cmdReadDir,
  output logic [31:0]       cmdArg,
  output logic [31:0]       bufAddr,
  output logic [LEN_W-1:0]  blkLenM1,
  output logic [LEN_W-1:0]  blkCntM1,
  input  logic              evCmdDone,
  input  logic              evDataDone,
  input  logic              evTimeout,
  input  logic [RESP_W-1:0] respIn,
  input  logic              cardInserted,
  input  logic              cardReadOnly
);
  ctrlStrb_t   strb;
  logic        busy;
  logic [31:0] cmdWord;

  assign cmdOpcode    = cmdWord[5:0];
  assign cmdOpenDrain = cmdWord[6];
  assign cmdRespType  = cmdWord[9:8];
  assign cmdBusyWait  = cmdWord[11];
  assign cmdClass     = cmdWord[13:12];
  assign cmdReadDir   = cmdWord[15];

  sdhost_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .evCmdDone(evCmdDone), .evDataDone(evDataDone), .evTimeout(evTimeout),
    .cardInserted(cardInserted), .curRespType(cmdWord[9:8]),
    .strb(strb), .busy(busy), .cmdStart(cmdStart)
  );

  sdhost_dpath #(.LEN_W(LEN_W), .RESP_W(RESP_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWdata(busWdata),
    .respIn(respIn), .busy(busy), .cardInserted(cardInserted),
    .cardReadOnly(cardReadOnly), .busRdata(busRdata), .irq(irq),
    .cmdWord(cmdWord), .cmdArg(cmdArg), .bufAddr(bufAddr),
    .blkLenM1(blkLenM1), .blkCntM1(blkCntM1)
  );
endmodule

// File: tb/sdhost_front_tb.sv
module sdhost_front_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 1'b0;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic irq, cmdStart, cmdOpenDrain, cmdBusyWait, cmdReadDir;
  logic [5:0] cmdOpcode;
  logic [1:0] cmdRespType, cmdClass;
  logic [31:0] cmdArg, bufAddr;
  logic [10:0] blkLenM1, blkCntM1;
  logic evCmdDone = 1'b0, evDataDone = 1'b0, evTimeout = 1'b0;
  logic [127:0] respIn = '0;
  logic cardInserted = 1'b0, cardReadOnly = 1'b0;

  int nChecks = 0, nFails = 0;
  logic [3:0] mStat = '0, mEn = '0;
  logic [31:0] mBuf = '0, mArg = '0;
  logic [10:0] mLen = '0, mCnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdhost_front dut_i (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  function automatic logic expIrq(input logic [3:0] s, input logic [3:0] e);
    return |(s & e);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  task automatic events(input logic cd, input logic dd, input logic to);
    @(negedge clk); evCmdDone = cd; evDataDone = dd; evTimeout = to;
    @(negedge clk); evCmdDone = 1'b0; evDataDone = 1'b0; evTimeout = 1'b0;
  endtask

  task automatic checkStat(input string req);
    logic [31:0] v;
    rd(6'h00, v);
    check(v, 32'(mStat), req);
    check(32'(irq), 32'(expIrq(mStat, mEn)), "R7 irq");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    logic [127:0] resp;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    for (int i = 0; i < 12; i++) begin
      rd(6'(i * 4), v);
      check(v, 32'h0, "R1 register reset");
    end
    check(32'(irq), 0, "R1 irq reset");
    check(32'(cmdStart), 0, "R1 start reset");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 5);
      logic [31:0] d = $urandom;
      case (op)
        0: begin
          int r = $urandom_range(0, 4);
          case (r)
            0: begin wr(6'h04, d); mEn = d[3:0]; end
            1: begin wr(6'h08, d); mBuf = d; end
            2: begin wr(6'h10, d); mArg = d; end
            3: begin wr(6'h24, d); mLen = d[10:0]; end
            default: begin wr(6'h28, d); mCnt = d[10:0]; end
          endcase
        end
        1: begin
          rd(6'h04, v); check(v, 32'(mEn), "R2 enable");
          rd(6'h08, v); check(v, mBuf, "R2 buffer");
          rd(6'h10, v); check(v, mArg, "R2 argument");
          rd(6'h24, v); check(v, 32'(mLen), "R2 length");
          rd(6'h28, v); check(v, 32'(mCnt), "R2 count");
          check(bufAddr, mBuf, "R2 bufAddr port");
          check(32'(blkLenM1), 32'(mLen), "R2 len port");
        end
        2: begin events(1'b0, 1'b1, 1'b0); mStat[1] = 1'b1; end
        3: begin
          @(negedge clk); cardInserted = ~cardInserted;
          @(negedge clk); mStat[2] = 1'b1;
          rd(6'h2C, v); check(v, {30'd0, cardReadOnly, cardInserted}, "R10 inserted");
        end
        4: begin wr(6'h00, d); mStat = mStat & ~d[3:0]; end
        default: begin
          @(negedge clk); cardReadOnly = d[0];
          rd(6'h2C, v); check(v, {30'd0, cardReadOnly, cardInserted}, "R10 read-only");
        end
      endcase
      checkStat("R5 R6 status");
    end

    // R2 upper bits of length read zero
    wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, v); check(v, 32'h7FF, "R2 length width");
    wr(6'h00, 32'hF); mStat = '0;
    wr(6'h04, 32'hF); mEn = 4'hF;

    // R3 command issue: opcode 0x2A, open-drain, long, busy-wait, class 3, read
    wr(6'h10, 32'hCAFE_0001);
    wr(6'h0C, 32'hFFFF_FA6A);
    check(32'(cmdStart), 1, "R3 start pulse");
    check({cmdOpcode, cmdOpenDrain, cmdRespType, cmdBusyWait, cmdClass, cmdReadDir},
          {6'h2A, 1'b1, 2'd2, 1'b1, 2'd3, 1'b1}, "R3 fields");
    check(cmdArg, 32'hCAFE_0001, "R3 argument");
    @(negedge clk); check(32'(cmdStart), 0, "R3 start one cycle");
    rd(6'h0C, v); check(v, 32'h0000_BA6A, "R3 stored word");
    // R4 busy and ignored command
    rd(6'h2C, v); check(v[31], 1, "R4 busy set");
    wr(6'h0C, 32'h0000_0101);
    check(32'(cmdStart), 0, "R4 no start while busy");
    rd(6'h0C, v); check(v, 32'h0000_BA6A, "R4 command kept");
    // R9 long response
    resp = {32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111};
    respIn = resp;
    events(1'b1, 1'b0, 1'b0); mStat[0] = 1'b1;
    for (int w = 0; w < 4; w++) begin
      rd(6'(8'h14 + w * 4), v); check(v, resp[w*32 +: 32], "R9 long word");
    end
    rd(6'h2C, v); check(v[31], 0, "R4 busy cleared");
    checkStat("R5 end of command");
    // R9 short response
    wr(6'h0C, 32'h0000_0111);
    respIn = {96'hAAAA, 32'h5555_0000};
    events(1'b1, 1'b0, 1'b0);
    rd(6'h14, v); check(v, 32'h5555_0000, "R9 short word0");
    rd(6'h18, v); check(v, 32'h0, "R9 short word1 cleared");
    // R9 no response
    wr(6'h0C, 32'h0000_0000);
    respIn = {4{32'hDEAD_BEEF}};
    events(1'b1, 1'b0, 1'b0);
    rd(6'h14, v); check(v, 32'h5555_0000, "R9 none leaves word0");
    // R8 timeout with done
    wr(6'h00, 32'hF); mStat = '0;
    wr(6'h0C, 32'h0000_0102);
    events(1'b1, 1'b0, 1'b1); mStat[3] = 1'b1;
    checkStat("R8 timeout only");
    rd(6'h14, v); check(v, 32'h5555_0000, "R8 no response load");
    rd(6'h2C, v); check(v[31], 0, "R8 busy cleared");
    // R6 event and clear in the same cycle
    @(negedge clk); busWr = 1'b1; busAddr = 6'h00; busWdata = 32'h2; evDataDone = 1'b1;
    @(negedge clk); busWr = 1'b0; evDataDone = 1'b0; mStat[1] = 1'b1;
    checkStat("R6 event beats clear");
    // R7 masking
    wr(6'h04, 32'h1); mEn = 4'h1;
    check(32'(irq), 0, "R7 masked irq");
    summary();
  end
endmodule